// File: doc/BRIEF.md
# I2C Target Address Front-End

This block is the bus-facing part of an I2C target. A fast system clock oversamples the serial clock and data lines through a synchronizer. The block finds Start and Stop conditions. It receives the address byte and checks it against a fixed prefix joined to a strapped address-select input. The strap is captured when Start is seen. When the address matches, the block pulls SDA low for the acknowledge clock and reports the transfer direction.

After the address phase, the block carries data in either direction. In a write it collects bytes from the controller, reports each completed byte, and acknowledges it. In a read it asks the downstream logic for a byte, then shifts that byte onto the bus. It goes on sending bytes for as long as the controller acknowledges them. The register bank that supplies and consumes the bytes sits outside this block. SDA is driven as an open-drain enable: when the enable is high, the line is pulled low.

Top module: `i2ct_front`

## Requirements
- R1: After reset `sda_oe_o`, `rx_valid_o`, `rd_req_o` and `dir_o` are all 0, so the data line is released.
- R2: After a Start, in which SDA falls while SCL is high, the block takes 8 bits MSB first, one per SCL high phase. If the first 7 bits equal `0100000` with the last bit replaced by the latched strap, it holds `sda_oe_o` at 1 for the whole high phase of the ninth clock.
- R3: If the address does not match, SDA stays released on the ninth clock and on every later clock. No byte is reported until the next Start.
- R4: The strap `addr_pin_i` is captured at Start. A change to the strap after Start has no effect on the decode of that transfer. The next transfer's decode uses the new strap value.
- R5: In a write, which is direction bit 0, each data byte is received MSB first. The byte appears on `rx_data_o` with a one-cycle `rx_valid_o` pulse, and the block acknowledges it on the next SCL clock.
- R6: `dir_o` is set to the address byte's last bit (1 = read) on a match. It is 0 after a Stop.
- R7: In a read, `rd_req_o` pulses once at the address match and once after each byte the controller acknowledges. The value on `tx_data_i` is loaded when SCL falls after that pulse, and it is driven MSB first, one bit per clock.
- R8: If the controller does not acknowledge a read byte (SDA high on the ninth clock), the block stops driving and leaves SDA released until the next Start.
- R9: A Stop, in which SDA rises while SCL is high, returns the block to idle and releases SDA.
- R10: A repeated Start in any state discards any partial byte and restarts address reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| addr_pin_i | input | ADDR_PIN_W | Strapped address-select input |
| tx_data_i | input | 8 | Byte to send during a read |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |
| rx_valid_o | output | 1 | One-cycle pulse when a write byte is complete |
| rx_data_o | output | 8 | Last byte received in a write |
| rd_req_o | output | 1 | One-cycle pulse asking for the next read byte |
| dir_o | output | 1 | Direction of the current transfer, 1 = read |

## Verification
The hardest case to reach from the ports is a change of the strap during a transfer. The decode must keep using the value captured at Start. The bench raises the strap, sends a Start, and lowers the strap before the first address bit. It then expects an acknowledge for the old address and a refusal of that same address in the next transfer. A repeated Start after only three bits of a byte checks that the partial shift is discarded. A read that ends with a controller non-acknowledge checks that the target truly goes silent: the bench reads a further byte and must see all ones.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
   localparam int BYTE_W = 8;
   localparam int ADDR_W = 7;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ACK_SET,
      ST_ACK_HOLD,
      ST_WR_DATA,
      ST_RD_DATA,
      ST_RD_ACK,
      ST_RD_LOAD,
      ST_WAIT
   } eng_state_t;
endpackage

// File: rtl/i2ct_sync.sv
module i2ct_sync #(
   parameter int STAGES = 2,
   parameter int LANES  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LANES-1:0] d_i,
   output logic [LANES-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("i2ct_sync: STAGES must be at least 2");
   end

   for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '1;
         else        chain <= {chain[STAGES-2:0], d_i[ln]};
      end
      assign q_o[ln] = chain[STAGES-1];
   end
endmodule

// File: rtl/i2ct_cond.sv
module i2ct_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic start_o,
   output logic stop_o,
   output logic rise_o,
   output logic fall_o
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign start_o = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_o  = scl_s & scl_q & ~sda_q & sda_s;
   assign rise_o  = scl_s & ~scl_q;
   assign fall_o  = ~scl_s & scl_q;

   a_r9_cond_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(start_o && stop_o) && !(rise_o && fall_o));
   // R2: a control condition never coincides with a clock edge
   a_r2_cond_not_edge: assert property (@(posedge clk) disable iff (!rst_n)
      (start_o || stop_o) |-> !(rise_o || fall_o));
endmodule

// File: rtl/i2ct_engine.sv
module i2ct_engine
   import i2ct_pkg::*;
#(
   parameter int                          ADDR_PIN_W = 1,
   parameter logic [ADDR_W-ADDR_PIN_W-1:0] PREFIX    = '0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  sda_s,
   input  logic                  start_i,
   input  logic                  stop_i,
   input  logic                  rise_i,
   input  logic                  fall_i,
   input  logic [ADDR_PIN_W-1:0] addr_pin_i,
   input  logic [BYTE_W-1:0]     tx_data_i,
   output logic                  sda_oe_o,
   output logic                  rx_valid_o,
   output logic [BYTE_W-1:0]     rx_data_o,
   output logic                  rd_req_o,
   output logic                  dir_o
);
   localparam int CNT_W = $clog2(BYTE_W);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

   eng_state_t              state;
   logic [CNT_W-1:0]        cnt;
   logic [BYTE_W-1:0]       sh;
   logic [ADDR_PIN_W-1:0]   pin_lat;
   logic [ADDR_W-1:0]       own_addr;

   assign own_addr = {PREFIX, pin_lat};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         cnt        <= '0;
         sh         <= '0;
         pin_lat    <= '0;
         sda_oe_o   <= 1'b0;
         rx_valid_o <= 1'b0;
         rx_data_o  <= '0;
         rd_req_o   <= 1'b0;
         dir_o      <= 1'b0;
      end else begin
         rx_valid_o <= 1'b0;
         rd_req_o   <= 1'b0;
         if (start_i) begin
            state    <= ST_ADDR;
            cnt      <= '0;
            pin_lat  <= addr_pin_i;
            sda_oe_o <= 1'b0;
            dir_o    <= 1'b0;
         end else if (stop_i) begin
            state    <= ST_IDLE;
            sda_oe_o <= 1'b0;
            dir_o    <= 1'b0;
         end else begin
            unique case (state)
               ST_ADDR: if (rise_i) begin
                  sh  <= {sh[BYTE_W-2:0], sda_s};
                  cnt <= cnt + 1'b1;
                  if (cnt == LAST_BIT) begin
                     if (sh[ADDR_W-1:0] == own_addr) begin
                        dir_o    <= sda_s;
                        rd_req_o <= sda_s;
                        state    <= ST_ACK_SET;
                     end else begin
                        state <= ST_WAIT;
                     end
                  end
               end
               ST_ACK_SET: if (fall_i) begin
                  sda_oe_o <= 1'b1;
                  state    <= ST_ACK_HOLD;
               end
               ST_ACK_HOLD: if (fall_i) begin
                  cnt <= '0;
                  if (dir_o) begin
                     sh       <= tx_data_i;
                     sda_oe_o <= ~tx_data_i[BYTE_W-1];
                     state    <= ST_RD_DATA;
                  end else begin
                     sda_oe_o <= 1'b0;
                     state    <= ST_WR_DATA;
                  end
               end
               ST_WR_DATA: if (rise_i) begin
                  sh  <= {sh[BYTE_W-2:0], sda_s};
                  cnt <= cnt + 1'b1;
                  if (cnt == LAST_BIT) begin
                     rx_data_o  <= {sh[BYTE_W-2:0], sda_s};
                     rx_valid_o <= 1'b1;
                     state      <= ST_ACK_SET;
                  end
               end
               ST_RD_DATA: if (fall_i) begin
                  if (cnt == LAST_BIT) begin
                     sda_oe_o <= 1'b0;
                     state    <= ST_RD_ACK;
                  end else begin
                     cnt      <= cnt + 1'b1;
                     sh       <= {sh[BYTE_W-2:0], 1'b0};
                     sda_oe_o <= ~sh[BYTE_W-2];
                  end
               end
               ST_RD_ACK: if (rise_i) begin
                  if (!sda_s) begin
                     rd_req_o <= 1'b1;
                     state    <= ST_RD_LOAD;
                  end else begin
                     state <= ST_WAIT;
                  end
               end
               ST_RD_LOAD: if (fall_i) begin
                  cnt      <= '0;
                  sh       <= tx_data_i;
                  sda_oe_o <= ~tx_data_i[BYTE_W-1];
                  state    <= ST_RD_DATA;
               end
               default: ;
            endcase
         end
      end
   end

   // R9: a Stop releases the line on the next cycle
   a_r9_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
      stop_i && !start_i |=> !sda_oe_o && state == ST_IDLE);
   // R10: every Start restarts address reception from bit zero
   a_r10_restart: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> state == ST_ADDR && cnt == '0);
   // R4: the captured strap only changes at a Start
   a_r4_strap_held: assert property (@(posedge clk) disable iff (!rst_n)
      !start_i |=> $stable(pin_lat));
   // R3 / R8: a silent target never pulls the line
   a_r3_wait_silent: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_WAIT |-> !sda_oe_o);
   // R5: byte report is a single-cycle pulse
   a_r5_rx_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid_o |=> !rx_valid_o);
   // R7: a read request only occurs in a read
   a_r7_req_in_read: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_o |-> dir_o);
endmodule

// File: rtl/i2ct_front.sv
module i2ct_front
   import i2ct_pkg::*;
#(
   parameter int                          SYNC_STAGES = 2,
   parameter int                          ADDR_PIN_W  = 1,
   parameter logic [ADDR_W-ADDR_PIN_W-1:0] PREFIX     = 6'b010000
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  scl_i,
   input  logic                  sda_i,
   input  logic [ADDR_PIN_W-1:0] addr_pin_i,
   input  logic [BYTE_W-1:0]     tx_data_i,
   output logic                  sda_oe_o,
   output logic                  rx_valid_o,
   output logic [BYTE_W-1:0]     rx_data_o,
   output logic                  rd_req_o,
   output logic                  dir_o
);
   if (ADDR_PIN_W < 1 || ADDR_PIN_W > 3) begin : g_bad_pin_w
      $error("i2ct_front: ADDR_PIN_W must be 1 to 3");
   end

   logic [1:0] bus_s;
   logic       start_w, stop_w, rise_w, fall_w;

   i2ct_sync #(.STAGES(SYNC_STAGES), .LANES(2)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({scl_i, sda_i}),
      .q_o   (bus_s)
   );

   i2ct_cond u_cond (
      .clk     (clk),
      .rst_n   (rst_n),
      .scl_s   (bus_s[1]),
      .sda_s   (bus_s[0]),
      .start_o (start_w),
      .stop_o  (stop_w),
      .rise_o  (rise_w),
      .fall_o  (fall_w)
   );

   i2ct_engine #(.ADDR_PIN_W(ADDR_PIN_W), .PREFIX(PREFIX)) u_eng (
      .clk        (clk),
      .rst_n      (rst_n),
      .sda_s      (bus_s[0]),
      .start_i    (start_w),
      .stop_i     (stop_w),
      .rise_i     (rise_w),
      .fall_i     (fall_w),
      .addr_pin_i (addr_pin_i),
      .tx_data_i  (tx_data_i),
      .sda_oe_o   (sda_oe_o),
      .rx_valid_o (rx_valid_o),
      .rx_data_o  (rx_data_o),
      .rd_req_o   (rd_req_o),
      .dir_o      (dir_o)
   );
endmodule

// File: tb/sim_i2ct_front.sv
module sim_i2ct_front;
   localparam int CLK_P = 10;
   localparam int HP    = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl = 1'b1;
   logic       sda_m = 1'b1;
   logic [0:0] pin = 1'b1;
   logic [7:0] tx = 8'h00;
   logic       sda_oe, rx_valid, rd_req, dir;
   logic [7:0] rx_data;
   logic       sda_bus;

   int tests = 0;
   int fails = 0;
   int rx_cnt = 0;
   int rd_cnt = 0;
   logic [7:0] rx_last = 8'h00;
   bit done = 1'b0;

   assign sda_bus = sda_m & ~sda_oe;

   always #(CLK_P/2) clk = ~clk;

   i2ct_front u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (scl),
      .sda_i      (sda_bus),
      .addr_pin_i (pin),
      .tx_data_i  (tx),
      .sda_oe_o   (sda_oe),
      .rx_valid_o (rx_valid),
      .rx_data_o  (rx_data),
      .rd_req_o   (rd_req),
      .dir_o      (dir)
   );

   always @(negedge clk) begin
      if (rx_valid) begin
         rx_cnt  <= rx_cnt + 1;
         rx_last <= rx_data;
      end
      if (rd_req) rd_cnt <= rd_cnt + 1;
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wt(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start;
      sda_m = 1'b1; wt(HP);
      scl = 1'b1;   wt(HP);
      sda_m = 1'b0; wt(HP);
      scl = 1'b0;
   endtask

   task automatic bus_stop;
      scl = 1'b0; sda_m = 1'b0; wt(HP);
      scl = 1'b1; wt(HP);
      sda_m = 1'b1; wt(HP);
   endtask

   task automatic put_bit(input logic b);
      sda_m = b; wt(HP);
      scl = 1'b1; wt(HP);
      scl = 1'b0;
   endtask

   task automatic get_bit(output logic b);
      sda_m = 1'b1; wt(HP);
      scl = 1'b1; wt(HP/2);
      b = sda_bus; wt(HP/2);
      scl = 1'b0;
   endtask

   task automatic put_byte(input logic [7:0] v, output bit acked);
      logic a;
      for (int i = 7; i >= 0; i--) put_bit(v[i]);
      get_bit(a);
      acked = !a;
   endtask

   task automatic get_byte(output logic [7:0] v, input logic nack, input logic [7:0] nxt);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         get_bit(b);
         v[i] = b;
      end
      tx = nxt;
      put_bit(nack);
   endtask

   task automatic t_reset;
      chk(sda_oe == 1'b0, "R1 sda_oe", sda_oe, 0);
      chk(rx_valid == 1'b0 && rd_req == 1'b0, "R1 pulses", {rx_valid, rd_req}, 0);
      chk(dir == 1'b0, "R1 dir", dir, 0);
   endtask

   task automatic t_write;
      bit ak;
      pin = 1'b1;
      bus_start;
      put_byte(8'h42, ak);
      chk(ak, "R2 address ack", ak, 1);
      chk(dir == 1'b0, "R6 dir write", dir, 0);
      put_byte(8'hB6, ak);
      chk(ak, "R5 data ack", ak, 1);
      chk(rx_cnt == 1 && rx_last == 8'hB6, "R5 first byte", rx_last, 8'hB6);
      put_byte(8'h01, ak);
      chk(rx_cnt == 2 && rx_last == 8'h01, "R5 second byte", rx_last, 8'h01);
      bus_stop;
      chk(sda_oe == 1'b0, "R9 released after stop", sda_oe, 0);
   endtask

   task automatic t_mismatch;
      bit ak;
      int c0 = rx_cnt;
      bus_start;
      put_byte(8'h50, ak);
      chk(!ak, "R3 no ack on mismatch", ak, 0);
      put_byte(8'h00, ak);
      chk(!ak, "R3 silent on data", ak, 0);
      chk(rx_cnt == c0, "R3 no byte report", rx_cnt, c0);
      bus_stop;
   endtask

   task automatic t_latch;
      bit ak;
      pin = 1'b1;
      bus_start;
      pin = 1'b0;
      put_byte(8'h42, ak);
      chk(ak, "R4 strap held from start", ak, 1);
      bus_stop;
      bus_start;
      put_byte(8'h42, ak);
      chk(!ak, "R4 new strap refuses old address", ak, 0);
      bus_stop;
      bus_start;
      put_byte(8'h40, ak);
      chk(ak, "R4 new strap accepts new address", ak, 1);
      bus_stop;
      pin = 1'b1;
   endtask

   task automatic t_restart;
      bit ak;
      int c0;
      bus_start;
      put_byte(8'h42, ak);
      c0 = rx_cnt;
      put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
      bus_start;
      put_byte(8'h42, ak);
      chk(ak, "R10 address after repeated start", ak, 1);
      put_byte(8'h9C, ak);
      chk(rx_cnt == c0 + 1 && rx_last == 8'h9C, "R10 clean byte after restart", rx_last, 8'h9C);
      bus_stop;
   endtask

   task automatic t_read;
      bit ak;
      logic [7:0] d;
      int r0 = rd_cnt;
      tx = 8'hA5;
      bus_start;
      put_byte(8'h43, ak);
      chk(ak, "R2 read address ack", ak, 1);
      chk(dir == 1'b1, "R6 dir read", dir, 1);
      chk(rd_cnt == r0 + 1, "R7 request at match", rd_cnt, r0 + 1);
      get_byte(d, 1'b0, 8'h3C);
      chk(d == 8'hA5, "R7 first read byte", d, 8'hA5);
      chk(rd_cnt == r0 + 2, "R7 request after ack", rd_cnt, r0 + 2);
      get_byte(d, 1'b1, 8'h00);
      chk(d == 8'h3C, "R7 second read byte", d, 8'h3C);
      chk(rd_cnt == r0 + 2, "R8 no request after nack", rd_cnt, r0 + 2);
      get_byte(d, 1'b1, 8'h00);
      chk(d == 8'hFF, "R8 line released after nack", d, 8'hFF);
      bus_stop;
      chk(dir == 1'b0, "R6 dir cleared by stop", dir, 0);
      chk(sda_oe == 1'b0, "R9 idle after read", sda_oe, 0);
   endtask

   initial begin
      wt(3);
      rst_n = 1'b1;
      wt(4);
      t_reset;
      t_write;
      t_mismatch;
      t_latch;
      t_restart;
      t_read;
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule